// File: doc/BRIEF.md
# On-off keyed carrier modulator

This block makes the keyed carrier for a coax line modem. It runs from one reference clock at four times the carrier frequency, for example an 8.704 MHz reference for a 2.176 MHz carrier. The carrier is a one-bit square wave for an external analog output stage to shape and amplify. A fixed integer divider derives it from the reference. A transmit-data line keys the carrier on and off: low data means carrier and high data means silence. A two-bit mode input can force a standby state that silences the carrier whatever the data does.

The transmit data comes from another clock domain, so it passes through a synchroniser first. A key change waits for the end of the current carrier period, so every burst consists only of whole carrier cycles. A phase-zero strobe at reference-clock resolution is also provided. It lets neighbouring modems align to the same carrier phase. All logic sits in the reference clock domain with a synchronous, active-high reset.

Top module: `ook_carrier_mod`

## Requirements
- R1: While reset is held and in the first cycle after it, `carrier_o` is 0, the divider phase is 0 and `phase_strobe_o` is 1.
- R2: The divider phase runs 0,1,...,DIV-1 and wraps, so one carrier period is exactly DIV reference cycles (DIV=4 by default). While keyed, `carrier_o` is 1 in phases 0 to DIV/2-1 and 0 in the other phases.
- R3: When the synchronised transmit data is 0, the carrier is emitted from the next period boundary on. When it is 1, `carrier_o` stays 0 from the next boundary on.
- R4: Mode code 2'b11 is standby. A key decision taken while the mode is 2'b11 is always "off", so `carrier_o` stays 0 at any `tx_n_i` level.
- R5: Mode codes 2'b00, 2'b01 and 2'b10 all key the carrier the same way, from the transmit data.
- R6: `tx_n_i` passes through two reset-to-1 flops before use. The key decision made at a clock edge uses the value `tx_n_i` had two edges earlier.
- R7: The key state changes only at the edge where the phase wraps from DIV-1 to 0. Every high pulse of `carrier_o` therefore lasts exactly DIV/2 cycles, and no pulse ever starts in a phase other than 0.
- R8: `phase_strobe_o` is 1 for exactly one cycle in every DIV cycles, in the cycle where the phase is 0.
- R9: When not keyed, `carrier_o` is the constant level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, DIV times the carrier frequency |
| rst_i | input | 1 | Synchronous active-high reset |
| tx_n_i | input | 1 | Transmit data, active low (0 = send carrier), asynchronous |
| mode_i | input | 2 | Mode code; 2'b11 = standby, other codes key normally |
| carrier_o | output | 1 | Keyed one-bit carrier wave |
| phase_strobe_o | output | 1 | One-cycle pulse at carrier phase 0 |

## Verification
The data line is held steady for long runs in each normal mode. This separates a steady carrier from steady silence and shows the three normal codes behave the same. A sweep then drops and raises the data at every offset within the carrier period and with every burst length from one cycle to several periods. This tells apart a design that honours the two-flop delay and switches only at the wrap from one that switches early, late, or mid-period, which would leave short runt pulses. Standby is entered and left with the data held low, and also in the middle of a period. This shows the override wins and that leaving standby also waits for a boundary.

// File: rtl/ook_pkg.sv
package ook_pkg;

   localparam int MODE_W      = 2;
   localparam logic [MODE_W-1:0] STANDBY_CODE = 2'b11;

   // true when a mode code allows the carrier to be keyed
   function automatic logic mode_allows_key(input logic [MODE_W-1:0] m);
      return (m != STANDBY_CODE);
   endfunction

endpackage

// File: rtl/ook_phase_div.sv
module ook_phase_div #(
   parameter int DIV = 4
) (
   input  logic                       clk_i,
   input  logic                       rst_i,
   output logic [$clog2(DIV)-1:0]     phase_o,
   output logic [$clog2(DIV)-1:0]     phase_next_o,
   output logic                       wrap_o,
   output logic                       strobe_o
);
   localparam int PH_W = $clog2(DIV);
   localparam logic [PH_W-1:0] LAST = PH_W'(DIV - 1);

   logic [PH_W-1:0] phase_q;
   logic            strobe_q;

   assign wrap_o       = (phase_q == LAST);
   assign phase_next_o = wrap_o ? '0 : phase_q + 1'b1;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         phase_q  <= '0;
         strobe_q <= 1'b1;
      end else begin
         phase_q  <= phase_next_o;
         strobe_q <= (phase_next_o == '0);
      end
   end

   assign phase_o  = phase_q;
   assign strobe_o = strobe_q;

   a_r2_wraps_to_zero : assert property (@(posedge clk_i) disable iff (rst_i)
      (phase_q == LAST) |=> (phase_q == '0));
   a_r2_counts_up : assert property (@(posedge clk_i) disable iff (rst_i)
      (phase_q != LAST) |=> (phase_q == $past(phase_q) + 1'b1));
   a_r8_strobe_at_zero : assert property (@(posedge clk_i) disable iff (rst_i)
      strobe_q |-> (phase_q == '0));

endmodule

// File: rtl/ook_sync.sv
module ook_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk_i) begin
               if (rst_i) chain_q[0] <= RESET_VAL;
               else       chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i) begin
               if (rst_i) chain_q[i] <= RESET_VAL;
               else       chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/ook_key_gate.sv
module ook_key_gate
   import ook_pkg::*;
#(
   parameter int DIV = 4
) (
   input  logic                    clk_i,
   input  logic                    rst_i,
   input  logic                    tx_n_s_i,
   input  logic [MODE_W-1:0]       mode_i,
   input  logic                    wrap_i,
   input  logic [$clog2(DIV)-1:0]  phase_i,
   input  logic [$clog2(DIV)-1:0]  phase_next_i,
   output logic                    key_o,
   output logic                    carrier_o
);
   localparam int PH_W = $clog2(DIV);
   localparam logic [PH_W-1:0] HALF = PH_W'(DIV / 2);

   logic key_q, key_next, want_key, carrier_q;

   assign want_key = ~tx_n_s_i & mode_allows_key(mode_i);
   assign key_next = wrap_i ? want_key : key_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         key_q     <= 1'b0;
         carrier_q <= 1'b0;
      end else begin
         key_q     <= key_next;
         carrier_q <= key_next & (phase_next_i < HALF);
      end
   end

   assign key_o     = key_q;
   assign carrier_o = carrier_q;

   a_r7_key_only_at_wrap : assert property (@(posedge clk_i) disable iff (rst_i)
      (phase_i != '0) |-> $stable(key_q));
   a_r4_standby_forces_off : assert property (@(posedge clk_i) disable iff (rst_i)
      (wrap_i && (mode_i == STANDBY_CODE)) |=> !key_q);
   a_r7_rise_at_phase_zero : assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(carrier_q) |-> (phase_i == '0));
   a_r9_quiet_is_zero : assert property (@(posedge clk_i) disable iff (rst_i)
      !key_q |-> !carrier_q);
   a_r2_low_half : assert property (@(posedge clk_i) disable iff (rst_i)
      (phase_i >= HALF) |-> !carrier_q);

endmodule

// File: rtl/ook_carrier_mod.sv
module ook_carrier_mod
   import ook_pkg::*;
#(
   parameter int DIV         = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              tx_n_i,
   input  logic [1:0]        mode_i,
   output logic              carrier_o,
   output logic              phase_strobe_o
);
   localparam int PH_W = $clog2(DIV);

   generate
      if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
         $error("DIV must be an even number of at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (MODE_W != 2) begin : g_bad_mode
         $error("mode width must be 2");
      end
   endgenerate

   logic [PH_W-1:0] phase, phase_next;
   logic            wrap, tx_n_s, key;

   ook_phase_div #(.DIV(DIV)) u_div (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .phase_o      (phase),
      .phase_next_o (phase_next),
      .wrap_o       (wrap),
      .strobe_o     (phase_strobe_o)
   );

   ook_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   (tx_n_i),
      .q_o   (tx_n_s)
   );

   ook_key_gate #(.DIV(DIV)) u_gate (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .tx_n_s_i     (tx_n_s),
      .mode_i       (mode_i),
      .wrap_i       (wrap),
      .phase_i      (phase),
      .phase_next_i (phase_next),
      .key_o        (key),
      .carrier_o    (carrier_o)
   );

   a_r8_strobe_period : assert property (@(posedge clk_i) disable iff (rst_i)
      phase_strobe_o |=> !phase_strobe_o);
   a_r7_carrier_needs_key : assert property (@(posedge clk_i) disable iff (rst_i)
      carrier_o |-> key);

endmodule

// File: tb/tb_ook_carrier_mod.sv
`timescale 1ns/1ps
module tb_ook_carrier_mod;
   localparam int DIV  = 4;
   localparam int HALF = DIV / 2;

   logic       clk = 1'b0;
   logic       rst;
   logic       tx_n;
   logic [1:0] mode;
   logic       carrier, strobe;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   // bench model state
   bit m_s1, m_s2, m_key, m_car, m_stb;
   int m_ph;
   int run_len = 0;
   bit prev_car = 0;
   string cur_req = "R3";

   always #2.5 clk = ~clk;

   ook_carrier_mod #(.DIV(DIV), .SYNC_STAGES(2)) dut (
      .clk_i          (clk),
      .rst_i          (rst),
      .tx_n_i         (tx_n),
      .mode_i         (mode),
      .carrier_o      (carrier),
      .phase_strobe_o (strobe)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_s1 = 1; m_s2 = 1; m_key = 0; m_car = 0; m_stb = 1; m_ph = 0;
   endtask

   task automatic model_advance(input bit t, input bit [1:0] md);
      bit want, wrap;
      want = !m_s2 && (md != 2'b11);
      wrap = (m_ph == DIV - 1);
      m_s2 = m_s1;
      m_s1 = t;
      if (wrap) m_key = want;
      m_ph  = wrap ? 0 : m_ph + 1;
      m_car = m_key && (m_ph < HALF);
      m_stb = (m_ph == 0);
   endtask

   // one cycle: check outputs, then drive inputs for the next edge
   task automatic step(input bit t, input bit [1:0] md);
      @(negedge clk);
      check(cur_req, carrier, m_car);
      check("R8", strobe, m_stb);
      if (prev_car && !carrier) begin
         check("R7", (run_len == HALF), 1'b1);
         run_len = 0;
      end
      if (carrier) run_len++;
      prev_car = carrier;
      tx_n = t;
      mode = md;
      model_advance(t, md);
   endtask

   task automatic hold(input bit t, input bit [1:0] md, input int n);
      for (int i = 0; i < n; i++) step(t, md);
   endtask

   initial begin
      rst = 1; tx_n = 0; mode = 2'b00;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", carrier, 1'b0);
      check("R1", strobe, 1'b1);
      // release reset; data already low, first edge after reset
      rst = 0; tx_n = 1; mode = 2'b00;
      model_advance(1, 2'b00);

      // R9 / R3: idle high gives constant zero, then low keys carrier
      cur_req = "R9"; hold(1, 2'b00, 12);
      cur_req = "R3"; hold(0, 2'b00, 24); hold(1, 2'b00, 12);
      // R5: other normal codes behave the same
      cur_req = "R5";
      hold(0, 2'b01, 16); hold(1, 2'b01, 8);
      hold(0, 2'b10, 16); hold(1, 2'b10, 8);
      // R4: standby with data low, entered and left mid period
      cur_req = "R4";
      hold(0, 2'b00, 10); hold(0, 2'b11, 21); hold(0, 2'b00, 13);
      hold(1, 2'b11, 5);  hold(0, 2'b11, 7);  hold(1, 2'b00, 9);
      // R6 / R7 sweep: every offset and burst length
      cur_req = "R6";
      for (int off = 0; off < DIV; off++)
         for (int len = 1; len <= 3 * DIV; len++) begin
            hold(1, 2'b00, off + 2 * DIV);
            hold(0, 2'b00, len);
         end
      cur_req = "R7";
      for (int len = 1; len <= 2 * DIV; len++) begin
         hold(0, 2'b10, len);
         hold(1, 2'b10, len);
      end
      cur_req = "R2"; hold(0, 2'b01, 4 * DIV + 3);
      hold(1, 2'b00, 3 * DIV);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(5 * 100000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule